// File: doc/BRIEF.md
# CPU Power and Debug Mode Controller

This block sequences the power and debug modes of a small CPU core. It watches decoded instruction strobes (wait, stop, background-halt, software interrupt), the interrupt state, a debug-enable control bit, a periodic wakeup tick and decoded serial debug commands. From these it drives the CPU clock enable, the oscillator enable, a strobe that clears the core's global interrupt mask, an interrupt-accept strobe, and a 2-bit mode code.

Internally there are five named states: `ST_RUN`, `ST_WAIT`, `ST_STOP`, `ST_HALT` (background debug halt) and `ST_STEP` (one traced instruction). The transitions are as follows. Run goes to halt on the background-halt strobe, to stop on the stop strobe, and to wait on the wait strobe. Wait goes to halt on any debug command, and to run on a pending interrupt. Stop goes to halt on a debug command while debug is enabled, and to run on a pending interrupt or a wakeup tick. Halt goes to run on a go or tagged-go command, and to step on a trace command. Step returns to halt on the instruction-complete pulse. Reset is synchronous. It goes to run, or to halt if the debug request is held during reset.

Top module: `cpu_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, each clock edge sets mode 00 with `cpu_clk_en`=1, `osc_en`=1, `mask_clear`=0 and `irq_accept`=0. If `dbg_req` is high during reset, the mode is 11 instead, with both clock enables still 1.
- R2: The mode output encodes run=00, wait=01, stop=10 and halt=11. A traced instruction reports 00.
- R3: In run, `ins_wait` moves the block to wait at the next edge. At that edge `cpu_clk_en` drops, and `mask_clear` pulses high for exactly that one cycle.
- R4: In wait, a pending interrupt returns the block to run with `cpu_clk_en`=1 at the next edge. A wait entered while an interrupt is already pending therefore lasts exactly one cycle.
- R5: In wait, any debug command (code 00, 01, 10 or 11) moves the block to halt with `cpu_clk_en`=1. A command takes priority over a pending interrupt.
- R6: Entering stop drops `cpu_clk_en`. At entry, `osc_en` takes the value of `dbg_enable`, and it returns to 1 when stop is left.
- R7: In stop, a pending interrupt or a `wake_tick` pulse returns the block to run. The tick is honoured when the parameter `TICK_WAKE_EN` is 1.
- R8: In stop, a debug command moves the block to halt only if `dbg_enable` is 1. With `dbg_enable` at 0 the command is ignored and the block stays in stop.
- R9: In run, the strobes are prioritised as background-halt first, then stop, then wait.
- R10: Halt is left only by reset, by go (code 01) or by tagged-go (code 11), each of which leads to run. Other commands (code 00) and instruction strobes leave halt unchanged.
- R11: In halt, a trace command (code 10) enables the CPU clock and reports mode 00 until `insn_done` pulses. At the next edge the block is back in halt.
- R12: In run, `irq_accept` pulses one cycle after `ins_swi` whatever `irq_mask` is. It also pulses one cycle after `irq_pending` when `irq_mask` is 0, and stays low for a masked interrupt.
- R13: `cpu_clk_en` and `osc_en` are registered and change only at edges where the state changes. In particular, `osc_en` holds through stop even if `dbg_enable` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_req | input | 1 | Debug request, sampled while in reset |
| ins_wait | input | 1 | Wait instruction decoded |
| ins_stop | input | 1 | Stop instruction decoded |
| ins_bgnd | input | 1 | Background-halt instruction decoded |
| ins_swi | input | 1 | Software interrupt instruction decoded |
| insn_done | input | 1 | Instruction-complete pulse from the core |
| irq_pending | input | 1 | Hardware interrupt pending |
| irq_mask | input | 1 | Core's global interrupt mask bit |
| dbg_enable | input | 1 | Debug enable control bit |
| wake_tick | input | 1 | Periodic wakeup tick |
| cmd_valid | input | 1 | Debug command strobe |
| cmd_code | input | 2 | 00 other, 01 go, 10 trace, 11 tagged-go |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator enable |
| mask_clear | output | 1 | Clear global interrupt mask strobe |
| irq_accept | output | 1 | Interrupt taken strobe |
| mode | output | 2 | Current mode code |

## Verification
The bench targets the collisions between wake sources.

- **Command and interrupt together in wait.** A design that let the interrupt win would report mode 00 instead of 11.
- **Debug command in stop with debug disabled.** Treating it like the wait case would leave stop wrongly.
- **Wait entered with an interrupt already pending.** A design that lost the pending event would stay asleep.
- **Trace step.** Returning to run instead of halt after `insn_done` shows as a mode of 00 where 11 is expected.
- **Halt held against non-resume commands.** A design that let other commands out of halt would be caught here.
- **Oscillator enable during stop.** Recomputing `osc_en` from the live debug-enable bit would let it drop mid-stop.
- **Software interrupt with the mask set.** A design that gated it by the mask would miss the accept pulse.

// File: rtl/cpu_mode_pkg.sv
package cpu_mode_pkg;

    localparam int CMD_W  = 2;
    localparam int MODE_W = 2;

    typedef enum logic [2:0] {
        ST_RUN  = 3'd0,
        ST_WAIT = 3'd1,
        ST_STOP = 3'd2,
        ST_HALT = 3'd3,
        ST_STEP = 3'd4
    } state_e;

    typedef enum logic [CMD_W-1:0] {
        CMD_OTHER = 2'b00,
        CMD_GO    = 2'b01,
        CMD_TRACE = 2'b10,
        CMD_TAGGO = 2'b11
    } dbg_cmd_e;

    localparam logic [MODE_W-1:0] MODE_RUN  = 2'b00;
    localparam logic [MODE_W-1:0] MODE_WAIT = 2'b01;
    localparam logic [MODE_W-1:0] MODE_STOP = 2'b10;
    localparam logic [MODE_W-1:0] MODE_HALT = 2'b11;

    // Decoded wake and exit events, one bit each.
    typedef struct packed {
        logic resume;     // go or tagged-go
        logic step;       // trace
        logic any_cmd;    // any command at all
        logic stop_dbg;   // command accepted while stopped
        logic wait_wake;  // interrupt ends wait
        logic stop_wake;  // interrupt or tick ends stop
    } wake_t;

    function automatic logic [MODE_W-1:0] mode_of(state_e s);
        logic [MODE_W-1:0] m;
        unique case (s)
            ST_RUN:  m = MODE_RUN;
            ST_WAIT: m = MODE_WAIT;
            ST_STOP: m = MODE_STOP;
            ST_HALT: m = MODE_HALT;
            ST_STEP: m = MODE_RUN;
            default: m = MODE_RUN;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/mode_wake_logic.sv
module mode_wake_logic
    import cpu_mode_pkg::*;
#(
    parameter bit TICK_WAKE_EN = 1'b1
) (
    input  logic             irq_pending,
    input  logic             wake_tick,
    input  logic             dbg_enable,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    output wake_t            ev
);

    logic tick_eff;

    generate
        if (TICK_WAKE_EN) begin : g_tick_on
            assign tick_eff = wake_tick;
        end else begin : g_tick_off
            logic unused_tick;
            assign unused_tick = wake_tick;
            assign tick_eff    = 1'b0;
        end
    endgenerate

    always_comb begin
        ev           = '0;
        ev.any_cmd   = cmd_valid;
        ev.resume    = cmd_valid && (cmd_code == CMD_GO || cmd_code == CMD_TAGGO);
        ev.step      = cmd_valid && (cmd_code == CMD_TRACE);
        ev.stop_dbg  = cmd_valid && dbg_enable;
        ev.wait_wake = irq_pending;
        ev.stop_wake = irq_pending || tick_eff;
    end

endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import cpu_mode_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   dbg_req,
    input  logic   ins_wait,
    input  logic   ins_stop,
    input  logic   ins_bgnd,
    input  logic   insn_done,
    input  wake_t  ev,
    output state_e state_q,
    output state_e state_d
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= dbg_req ? ST_HALT : ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (ins_bgnd)      state_d = ST_HALT;
                else if (ins_stop) state_d = ST_STOP;
                else if (ins_wait) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (ev.any_cmd)        state_d = ST_HALT;
                else if (ev.wait_wake) state_d = ST_RUN;
            end
            ST_STOP: begin
                if (ev.stop_dbg)       state_d = ST_HALT;
                else if (ev.stop_wake) state_d = ST_RUN;
            end
            ST_HALT: begin
                if (ev.resume)    state_d = ST_RUN;
                else if (ev.step) state_d = ST_STEP;
            end
            ST_STEP: begin
                if (insn_done) state_d = ST_HALT;
            end
            default: state_d = ST_RUN;
        endcase
    end

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !ev.resume && !ev.step) |=> state_q == ST_HALT); // R10
    AST_STEP_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && insn_done) |=> state_q == ST_HALT); // R11
    AST_WAIT_CMD_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && ev.any_cmd) |=> state_q == ST_HALT); // R5
    AST_BGND_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && ins_bgnd) |=> state_q == ST_HALT); // R9

endmodule

// File: rtl/mode_out_regs.sv
module mode_out_regs
    import cpu_mode_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  state_e state_q,
    input  state_e state_d,
    input  logic   dbg_enable,
    input  logic   ins_swi,
    input  logic   irq_pending,
    input  logic   irq_mask,
    output logic   cpu_clk_en,
    output logic   osc_en,
    output logic   mask_clear,
    output logic   irq_accept
);

    logic moving;
    logic sleep_next;

    assign moving     = (state_d != state_q);
    assign sleep_next = (state_d == ST_WAIT) || (state_d == ST_STOP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_clk_en <= 1'b1;
            osc_en     <= 1'b1;
            mask_clear <= 1'b0;
            irq_accept <= 1'b0;
        end else begin
            if (moving) begin
                cpu_clk_en <= !sleep_next;
                osc_en     <= (state_d == ST_STOP) ? dbg_enable : 1'b1;
            end
            mask_clear <= (state_q == ST_RUN) && (state_d == ST_WAIT);
            irq_accept <= (state_q == ST_RUN) && (ins_swi || (irq_pending && !irq_mask));
        end
    end

    AST_CLK_ON_MOVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == $past(state_q)) |-> ($stable(cpu_clk_en) && $stable(osc_en))); // R13
    AST_SWI_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && ins_swi) |=> irq_accept); // R12
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !ins_swi && irq_mask) |=> !irq_accept); // R12
    AST_SLEEP_CLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT || state_q == ST_STOP) |-> !cpu_clk_en); // R3
    AST_MCLR_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        mask_clear |-> state_q == ST_WAIT); // R3

endmodule

// File: rtl/cpu_mode_ctrl.sv
module cpu_mode_ctrl
    import cpu_mode_pkg::*;
#(
    parameter bit TICK_WAKE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_req,
    input  logic              ins_wait,
    input  logic              ins_stop,
    input  logic              ins_bgnd,
    input  logic              ins_swi,
    input  logic              insn_done,
    input  logic              irq_pending,
    input  logic              irq_mask,
    input  logic              dbg_enable,
    input  logic              wake_tick,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_code,
    output logic              cpu_clk_en,
    output logic              osc_en,
    output logic              mask_clear,
    output logic              irq_accept,
    output logic [1:0]        mode
);

    wake_t  ev;
    state_e state_q;
    state_e state_d;

    mode_wake_logic #(.TICK_WAKE_EN(TICK_WAKE_EN)) i_wake (
        .irq_pending (irq_pending),
        .wake_tick   (wake_tick),
        .dbg_enable  (dbg_enable),
        .cmd_valid   (cmd_valid),
        .cmd_code    (cmd_code),
        .ev          (ev)
    );

    mode_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .dbg_req   (dbg_req),
        .ins_wait  (ins_wait),
        .ins_stop  (ins_stop),
        .ins_bgnd  (ins_bgnd),
        .insn_done (insn_done),
        .ev        (ev),
        .state_q   (state_q),
        .state_d   (state_d)
    );

    mode_out_regs i_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_q     (state_q),
        .state_d     (state_d),
        .dbg_enable  (dbg_enable),
        .ins_swi     (ins_swi),
        .irq_pending (irq_pending),
        .irq_mask    (irq_mask),
        .cpu_clk_en  (cpu_clk_en),
        .osc_en      (osc_en),
        .mask_clear  (mask_clear),
        .irq_accept  (irq_accept)
    );

    assign mode = mode_of(state_q);

    AST_STOP_OSC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && cpu_clk_en && ins_stop && !ins_bgnd && dbg_enable
         && state_q == ST_RUN) |=> osc_en); // R6

endmodule

// File: tb/test_cpu_mode_ctrl.sv
`timescale 1ns/1ps
module test_cpu_mode_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       dbg_req;
    logic       ins_wait, ins_stop, ins_bgnd, ins_swi, insn_done;
    logic       irq_pending, irq_mask, dbg_enable, wake_tick, cmd_valid;
    logic [1:0] cmd_code;
    logic       cpu_clk_en, osc_en, mask_clear, irq_accept;
    logic [1:0] mode;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cpu_mode_ctrl i_cpu_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .dbg_req(dbg_req),
        .ins_wait(ins_wait), .ins_stop(ins_stop), .ins_bgnd(ins_bgnd),
        .ins_swi(ins_swi), .insn_done(insn_done),
        .irq_pending(irq_pending), .irq_mask(irq_mask),
        .dbg_enable(dbg_enable), .wake_tick(wake_tick),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .mask_clear(mask_clear),
        .irq_accept(irq_accept), .mode(mode)
    );

    // Input field order: wait stop bgnd swi | irq mask dben tick | cmdv cmd[1:0] done
    // Expected field order: mode[1:0] clk_en osc_en mask_clear irq_accept
    localparam int NV = 31;
    localparam logic [17:0] VEC [NV] = '{
        18'b0000_0000_0000_001100, // R2 idle run
        18'b0001_0100_0000_001101, // R12 swi with mask set
        18'b0000_1100_0000_001100, // R12 masked irq
        18'b0000_1000_0000_001101, // R12 unmasked irq
        18'b1000_0000_0000_010110, // R3 enter wait
        18'b0000_0000_0000_010100, // R3 stay wait
        18'b0000_1000_0000_001100, // R4 irq wakes
        18'b0000_0000_0000_001100, // R13 idle
        18'b1000_1100_0000_010110, // R4 wait with irq pending
        18'b0000_1100_0000_001100, // R4 one cycle later back in run
        18'b1000_0000_0000_010110, // R3 enter wait
        18'b0000_1000_1000_111100, // R5 cmd beats irq
        18'b0000_0000_1000_111100, // R10 other cmd holds halt
        18'b1000_0000_0000_111100, // R10 wait strobe ignored in halt
        18'b0000_0000_1010_001100, // R10 go
        18'b0100_0000_0000_100000, // R6 stop, osc off
        18'b0000_0000_1010_100000, // R8 cmd ignored without debug
        18'b0000_0001_0000_001100, // R7 tick wakes
        18'b0100_0010_0000_100100, // R6 stop with debug, osc on
        18'b0000_0000_0000_100100, // R13 osc held when debug drops
        18'b0000_1000_0000_001100, // R7 irq wakes stop
        18'b0100_0010_0000_100100, // R6 stop with debug
        18'b0000_0010_1100_111100, // R8 cmd enters halt
        18'b0000_0000_1100_001100, // R11 trace starts
        18'b0000_0000_0000_001100, // R11 step still running
        18'b0000_0000_0001_111100, // R11 done returns to halt
        18'b0000_0000_1110_001100, // R10 tagged go
        18'b1110_0000_0000_111100, // R9 bgnd wins
        18'b0000_0000_1010_001100, // R10 go
        18'b1100_0000_0000_100000, // R9 stop beats wait
        18'b0000_1000_0000_001100  // R7 irq wakes
    };
    localparam int VREQ [NV] = '{2,12,12,12,3,3,4,13,4,4,3,5,10,10,10,6,8,7,6,13,7,6,8,11,11,11,10,9,10,9,7};

    task automatic drive(input logic [11:0] v);
        {ins_wait, ins_stop, ins_bgnd, ins_swi,
         irq_pending, irq_mask, dbg_enable, wake_tick,
         cmd_valid, cmd_code, insn_done} = v;
    endtask

    task automatic check(input int req, input logic [5:0] exp);
        logic [5:0] act;
        act = {mode, cpu_clk_en, osc_en, mask_clear, irq_accept};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %b expected %b (mode clk osc mclr acc)", req, act, exp);
        end
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        dbg_req = 1'b0;
        drive(12'b0);
        repeat (3) @(negedge clk);
        check(1, 6'b001100); // R1 reset to run
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][17:6]);
            @(negedge clk);
            check(VREQ[i], VEC[i][5:0]);
        end
        // R1: reset from stop restores both enables
        drive(12'b0100_0000_0000);
        @(negedge clk);
        check(6, 6'b100000);
        drive(12'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check(1, 6'b001100); // R1 reset leaves stop
        // R1: debug request held in reset enters halt
        dbg_req = 1'b1;
        repeat (2) @(negedge clk);
        check(1, 6'b111100);
        rst_n = 1'b1;
        dbg_req = 1'b0;
        @(negedge clk);
        check(10, 6'b111100); // R10 stays halted without command
        drive(12'b0000_0000_1010);
        @(negedge clk);
        check(10, 6'b001100); // R10 go after reset-halt
        drive(12'b0);
        @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule